// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector with Three-State and Paired Error Outputs

This block is the phase comparator of a PLL. It compares two divided edge streams, one from the VCO and one from the reference. Each rising edge on an input arms a per-side flag. While exactly one flag is armed, the block reports which side is ahead.

The error appears in two forms at once:
- A single-ended three-state output. It is driven low when the VCO side is ahead, driven high when the reference side is ahead, and released otherwise. The release is shown as a separate enable signal, because the block is sampled logic on a fast system clock.
- A pair of active-low outputs, one per side, that follow the flags directly.

When both flags are armed, they stay armed together for a fixed minimum width and then clear together. This gives the short coincident low pulse on the pair that is seen in lock, and it avoids a dead zone around zero phase error. The charge pump, loop filter, dividers and any lock indication are outside the block.

Top module: `pfd_tristate`

## Requirements
- R1: While `rst_i` is high at a clock edge, the next state has both flags clear: `err_oe_o` = 0, `vco_err_n_o` = 1 and `ref_err_n_o` = 1.
- R2: While only the VCO flag is armed, `err_oe_o` = 1, `err_o` = 0, `vco_err_n_o` = 0 and `ref_err_n_o` = 1. The single-ended output gives negative pulses when the VCO is faster or leading.
- R3: While only the reference flag is armed, `err_oe_o` = 1, `err_o` = 1, `ref_err_n_o` = 0 and `vco_err_n_o` = 1. The single-ended output gives positive pulses when the VCO is slower or lagging.
- R4: Once both flags are armed, both pair outputs stay low for exactly CLR_DLY (default 2) cycles and then clear together. Throughout this window `err_oe_o` = 0.
- R5: With no flag armed, `err_oe_o` = 0. Whenever `err_oe_o` = 0, `err_o` = 0.
- R6: A rising input edge shows on the outputs two clock edges after the first edge that samples the input high. A steady level or a falling edge arms nothing. An input that is already high when reset is released counts as no edge.
- R7: An edge whose flag would arm on the same edge on which a coincident pair clears wins: that flag stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; samples both inputs |
| rst_i | input | 1 | Synchronous reset, active high |
| vco_in_i | input | 1 | Divided VCO edge stream |
| ref_in_i | input | 1 | Divided reference edge stream |
| err_o | output | 1 | Single-ended error level; meaningful only while enabled |
| err_oe_o | output | 1 | Enable of the single-ended error output; 0 means released |
| vco_err_n_o | output | 1 | Active-low VCO-side error |
| ref_err_n_o | output | 1 | Active-low reference-side error |

## Verification
The detector is driven in several ways, and each one separates a different behaviour:
- A VCO edge several cycles ahead of the reference edge, and the reverse. These separate negative from positive single-ended pulses and show which pair output is low.
- Edges arriving on the same cycle. These show the coincident minimum-width pulse with the single-ended output released.
- A VCO edge timed to land on the clearing cycle of a coincident pair. This shows that a new edge wins over the clear.
- Free-running streams of unequal period, followed by random edge timing. These mix every state transition, including inputs held high across reset, and every cycle is compared with a requirement-level model.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // Per-input sampling history used for rising-edge detection
    typedef struct packed {
        logic samp;
        logic prev;
    } edge_st_t;

    // Side selector for the edge-detector generate loop
    localparam int unsigned SIDE_VCO = 0;
    localparam int unsigned SIDE_REF = 1;
    localparam int unsigned NUM_SIDES = 2;

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det
    import pfd_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic sig_i,
    output logic rise_o
);

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.samp = sig_i;
        st_d.prev = st_q.samp;
        if (rst_i) begin
            // Preset high: a level already high at release is no edge
            st_d.samp = 1'b1;
            st_d.prev = 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign rise_o = st_q.samp & ~st_q.prev;

endmodule

// File: rtl/pfd_flag_core.sv
module pfd_flag_core #(
    parameter int unsigned CLR_DLY = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic vco_rise_i,
    input  logic ref_rise_i,
    output logic vco_flag_o,
    output logic ref_flag_o
);

    localparam int unsigned CNT_W = (CLR_DLY > 1) ? $clog2(CLR_DLY) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLR_DLY - 1);

    typedef struct packed {
        logic             vf;
        logic             rf;
        logic [CNT_W-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     both;
    logic     clr;

    always_comb begin
        both = st_q.vf & st_q.rf;
        clr  = both && (st_q.cnt == CNT_LAST);
        st_d = st_q;
        // A new edge wins over a simultaneous clear
        st_d.vf  = (st_q.vf & ~clr) | vco_rise_i;
        st_d.rf  = (st_q.rf & ~clr) | ref_rise_i;
        st_d.cnt = (both && !clr) ? st_q.cnt + 1'b1 : '0;
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign vco_flag_o = st_q.vf;
    assign ref_flag_o = st_q.rf;

endmodule

// File: rtl/pfd_out_enc.sv
module pfd_out_enc (
    input  logic vco_flag_i,
    input  logic ref_flag_i,
    output logic err_o,
    output logic err_oe_o,
    output logic vco_err_n_o,
    output logic ref_err_n_o
);

    always_comb begin
        err_oe_o    = vco_flag_i ^ ref_flag_i;
        err_o       = ref_flag_i & ~vco_flag_i;
        vco_err_n_o = ~vco_flag_i;
        ref_err_n_o = ~ref_flag_i;
    end

endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate
    import pfd_pkg::*;
#(
    parameter int unsigned CLR_DLY = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic vco_in_i,
    input  logic ref_in_i,
    output logic err_o,
    output logic err_oe_o,
    output logic vco_err_n_o,
    output logic ref_err_n_o
);

    logic [NUM_SIDES-1:0] in_vec;
    logic [NUM_SIDES-1:0] rise_vec;
    logic                 vco_flag;
    logic                 ref_flag;

    assign in_vec[SIDE_VCO] = vco_in_i;
    assign in_vec[SIDE_REF] = ref_in_i;

    for (genvar g = 0; g < NUM_SIDES; g++) begin : g_edge
        pfd_edge_det u_edge (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .sig_i  (in_vec[g]),
            .rise_o (rise_vec[g])
        );
    end

    pfd_flag_core #(
        .CLR_DLY (CLR_DLY)
    ) u_core (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .vco_rise_i (rise_vec[SIDE_VCO]),
        .ref_rise_i (rise_vec[SIDE_REF]),
        .vco_flag_o (vco_flag),
        .ref_flag_o (ref_flag)
    );

    pfd_out_enc u_enc (
        .vco_flag_i  (vco_flag),
        .ref_flag_i  (ref_flag),
        .err_o       (err_o),
        .err_oe_o    (err_oe_o),
        .vco_err_n_o (vco_err_n_o),
        .ref_err_n_o (ref_err_n_o)
    );

endmodule

// File: rtl/pfd_tristate_chk.sv
module pfd_tristate_chk (
    input logic clk_i,
    input logic rst_i,
    input logic vco_in_i,
    input logic err_o,
    input logic err_oe_o,
    input logic vco_err_n_o,
    input logic ref_err_n_o
);

    // R1
    reset_state_chk: assert property (@(posedge clk_i)
        rst_i |=> (vco_err_n_o && ref_err_n_o && !err_oe_o));

    // R2
    lead_drive_low_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (err_oe_o && !err_o) |-> (!vco_err_n_o && ref_err_n_o));

    // R3
    lag_drive_high_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (err_oe_o && err_o) |-> (!ref_err_n_o && vco_err_n_o));

    // R4
    coincident_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!vco_err_n_o && !ref_err_n_o) |-> !err_oe_o);

    // R5
    idle_release_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (vco_err_n_o && ref_err_n_o) |-> !err_oe_o);

    // R5
    released_level_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !err_oe_o |-> !err_o);

    // R6
    vco_edge_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(vco_err_n_o) |-> ($past(vco_in_i, 2) && !$past(vco_in_i, 3)));

endmodule

bind pfd_tristate pfd_tristate_chk chk_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .vco_in_i    (vco_in_i),
    .err_o       (err_o),
    .err_oe_o    (err_oe_o),
    .vco_err_n_o (vco_err_n_o),
    .ref_err_n_o (ref_err_n_o)
);

// File: tb/pfd_tristate_tb_top.sv
module pfd_tristate_tb_top;

    localparam int unsigned CLR_DLY = 2;
    localparam int unsigned WATCHDOG_CYC = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vco_in = 1'b0;
    logic ref_in = 1'b0;
    logic err, err_oe, vco_n, ref_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pfd_tristate #(.CLR_DLY(CLR_DLY)) dut_i (
        .clk_i       (clk),
        .rst_i       (rst),
        .vco_in_i    (vco_in),
        .ref_in_i    (ref_in),
        .err_o       (err),
        .err_oe_o    (err_oe),
        .vco_err_n_o (vco_n),
        .ref_err_n_o (ref_n)
    );

    // Requirement-level model: a rising edge arms its flag two edges
    // after it is first sampled (R6); a coincident pair holds CLR_DLY
    // cycles (R4); an edge on the clearing edge wins (R7).
    logic m_sv, m_pv, m_sr, m_pr, m_fv, m_fr;
    int   m_run;

    always @(posedge clk) begin
        if (rst) begin
            m_sv <= 1'b1; m_pv <= 1'b1; m_sr <= 1'b1; m_pr <= 1'b1;
            m_fv <= 1'b0; m_fr <= 1'b0; m_run <= 0;
        end else begin
            automatic bit rv  = m_sv && !m_pv;
            automatic bit rr  = m_sr && !m_pr;
            automatic bit bth = m_fv && m_fr;
            automatic bit clr = bth && (m_run == CLR_DLY - 1);
            m_sv <= vco_in; m_pv <= m_sv;
            m_sr <= ref_in; m_pr <= m_sr;
            m_fv <= (m_fv && !clr) || rv;
            m_fr <= (m_fr && !clr) || rr;
            m_run <= (bth && !clr) ? m_run + 1 : 0;
        end
    end

    function automatic logic [3:0] exp_out(input logic fv, input logic fr);
        // {err, err_oe, vco_n, ref_n}
        return {fr && !fv, fv ^ fr, !fv, !fr};
    endfunction

    function automatic string state_tag(input logic fv, input logic fr);
        if (fv && fr) return "R4";
        if (fv)       return "R2";
        if (fr)       return "R3";
        return "R5";
    endfunction

    task automatic check_now(input string tag);
        automatic logic [3:0] e = exp_out(m_fv, m_fr);
        automatic logic [3:0] a = {err, err_oe, vco_n, ref_n};
        automatic string t = (tag == "") ? state_tag(m_fv, m_fr) : tag;
        checks++;
        if (a !== e) begin
            errors++;
            $display("FAIL %s at %0t: {err,oe,vco_n,ref_n} actual %b expected %b",
                     t, $time, a, e);
        end
    endtask

    // Check at the falling edge, then drive the inputs for the next rise
    task automatic cyc(input logic v, input logic r, input string tag);
        @(negedge clk);
        check_now(tag);
        vco_in = v;
        ref_in = r;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, "");
    endtask

    initial begin
        #(WATCHDOG_CYC * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6: inputs held high through reset give no edge at release
        vco_in = 1'b1;
        ref_in = 1'b1;
        repeat (4) @(negedge clk);
        check_now("R1");
        rst = 1'b0;
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, "R6");
        idle(4);

        // R2: VCO edge five cycles ahead of the reference edge
        cyc(1'b1, 1'b0, "");
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b0, "");
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, "");
        idle(6);

        // R3: reference edge four cycles ahead
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, "");
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, "");
        idle(6);

        // R4: coincident edges give only the minimum-width pair pulse
        cyc(1'b1, 1'b1, "");
        for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, "R4");
        idle(6);

        // R7: second VCO edge lands on the clearing edge of the pair
        cyc(1'b1, 1'b1, "");
        cyc(1'b0, 1'b0, "");
        cyc(1'b1, 1'b0, "");
        cyc(1'b1, 1'b0, "R4");
        cyc(1'b1, 1'b0, "R7");
        cyc(1'b1, 1'b0, "R7");
        cyc(1'b1, 1'b1, "");
        idle(8);

        // Free-running streams with unequal periods (VCO faster, then slower)
        for (int pass = 0; pass < 2; pass++) begin
            automatic int pv = (pass == 0) ? 9 : 13;
            automatic int pr = 11;
            for (int i = 0; i < 800; i++)
                cyc(((i % pv) < pv / 2), ((i % pr) < pr / 2), "");
            idle(6);
        end

        // Random edge timing with a fixed seed, plus short resets
        void'($urandom(32'h5EED_0F0D));
        for (int i = 0; i < 4000; i++) begin
            automatic int unsigned rv = $urandom;
            if ((rv % 997) == 0) begin
                @(negedge clk);
                rst = 1'b1;
                vco_in = rv[8];
                ref_in = rv[9];
                @(negedge clk);
                check_now("R1");
                rst = 1'b0;
            end else begin
                cyc(rv[3:0] < 4'd5, rv[7:4] < 4'd5, "");
            end
        end
        idle(6);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule